// File: doc/BRIEF.md
# Adaptive Cache Way Enable Controller

This controller decides how many ways of a set-associative cache stay powered. The cache reports every lookup to it. Each report says whether the lookup hit and the recency position of the hit way among the ways that are currently enabled. Position 0 is the most recently used way.

Over an interval of a programmable number of lookups, the controller counts two kinds of hit, summed over all sets:
- hits in the most recent position;
- hits in the least recent enabled position.

At the end of the interval it compares the first count against the second count scaled by a high and a low threshold. The comparison uses multiplication, so no divider is needed. From the result it either shrinks the cache by one way, grows it by one way, or leaves it unchanged.

A way that is switched off loses its contents. Before it goes dark, its dirty lines must be written back through a request/acknowledge handshake with the cache. The enabled ways always form a contiguous group starting at way 0. The set index of an address is therefore never affected by a change in the number of ways.

Top module: `way_gate_ctrl`

## Requirements
- R1: After reset all NWAYS ways are enabled (`way_mask` all ones) and `flush_req` is low.
- R2: An interval ends with the lookup that brings the number of accepted lookups (`acc_valid` high) to `interval_len`. Cycles with `acc_valid` low are not counted. The decision is visible on the outputs after the clock edge that follows the edge accepting that final lookup.
- R3: A lookup counts as a most-recent hit when `acc_hit` is 1 and `acc_pos` is 0. It counts as a least-recent hit when `acc_hit` is 1 and `acc_pos` equals the number of enabled ways minus one. Misses and hits at any other position change neither count.
- R4: At an interval end, if the most-recent count exceeds the least-recent count times `thr_hi` and more than MIN_WAYS (2) ways are enabled, `flush_req` rises. `flush_way` then carries the index of the highest enabled way.
- R5: While `flush_req` is high and `flush_ack` is low, `way_mask` does not change. An edge with both high clears the flushed way's bit and drops `flush_req`.
- R6: At an interval end, if the most-recent count is below the least-recent count times `thr_lo` and fewer than NWAYS ways are enabled, the next way above the enabled group is enabled at once, with no handshake.
- R7: When the most-recent count lies between the two scaled limits (inclusive), the way mask is unchanged.
- R8: The number of enabled ways never drops below MIN_WAYS and never exceeds NWAYS. A request to go beyond either bound is ignored.
- R9: The mask changes by at most one way per interval. An interval that ends while a flush is pending makes no decision.
- R10: Both hit counts saturate at their maximum value. Both are cleared at every interval end, so that each interval is judged only on its own lookups.
- R11: The enabled ways are always ways 0 to N-1, where N is the number of enabled ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A lookup report is present |
| acc_hit | input | 1 | The lookup hit |
| acc_pos | input | $clog2(NWAYS) | Recency position of the hit way among the enabled ways, 0 = most recent |
| interval_len | input | IV_W | Lookups per interval (at least 1) |
| thr_hi | input | THR_W | Shrink threshold multiplier |
| thr_lo | input | THR_W | Grow threshold multiplier (not above thr_hi) |
| flush_ack | input | 1 | Cache finished writing back the way named by flush_way |
| way_mask | output | NWAYS | Enabled ways, bit i = way i |
| flush_req | output | 1 | Request to write back and invalidate a way |
| flush_way | output | $clog2(NWAYS) | Way to be flushed |

## Verification
The decision for an interval is due one clock after the edge that accepts the interval's final lookup. The bench therefore drives each lookup at a falling edge. After the last lookup of an interval it waits one further falling edge before sampling `way_mask`, `flush_req` and `flush_way`. The mask change for a flush is due on the edge that sees `flush_ack` high, and the bench samples at the falling edge after it. The no-change checks are the cases that leave the outputs untouched: a short interval, the hysteresis band, the floor and ceiling, and the saturated counter. Each of these is sampled in the same cycle in which a change would otherwise have appeared.

// File: rtl/way_gate_ctrl.sv
module way_gate_ctrl #(
  parameter int NWAYS    = 8,
  parameter int MIN_WAYS = 2,
  parameter int CNT_W    = 16,
  parameter int IV_W     = 16,
  parameter int THR_W    = 8,
  localparam int PW = $clog2(NWAYS),
  localparam int AW = $clog2(NWAYS + 1),
  localparam int MW = CNT_W + THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [PW-1:0]    acc_pos,
  input  logic [IV_W-1:0]  interval_len,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  input  logic             flush_ack,
  output logic [NWAYS-1:0] way_mask,
  output logic             flush_req,
  output logic [PW-1:0]    flush_way
);

  logic [AW-1:0]    active;
  logic [IV_W-1:0]  acc_cnt;
  logic [CNT_W-1:0] mru_cnt, lru_cnt;
  logic             eval;

  wire is_mru  = acc_valid && acc_hit && (acc_pos == '0);
  wire is_lru  = acc_valid && acc_hit && (AW'(acc_pos) == active - AW'(1));
  wire is_last = acc_valid && (acc_cnt == interval_len - IV_W'(1));

  wire [MW-1:0] mru_x  = {{THR_W{1'b0}}, mru_cnt};
  wire [MW-1:0] lim_hi = {{THR_W{1'b0}}, lru_cnt} * {{CNT_W{1'b0}}, thr_hi};
  wire [MW-1:0] lim_lo = {{THR_W{1'b0}}, lru_cnt} * {{CNT_W{1'b0}}, thr_lo};

  wire go_down = eval && !flush_req && (mru_x > lim_hi) && (active > AW'(MIN_WAYS));
  wire go_up   = eval && !flush_req && !go_down && (mru_x < lim_lo) && (active < AW'(NWAYS));

  genvar i;
  generate
    for (i = 0; i < NWAYS; i++) begin : g_mask
      assign way_mask[i] = (active > AW'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      eval    <= 1'b0;
    end else begin
      eval <= is_last;
      if (is_last)        acc_cnt <= '0;
      else if (acc_valid) acc_cnt <= acc_cnt + IV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mru_cnt <= '0;
      lru_cnt <= '0;
    end else if (eval) begin
      mru_cnt <= CNT_W'(is_mru);
      lru_cnt <= CNT_W'(is_lru);
    end else begin
      if (is_mru && mru_cnt != '1) mru_cnt <= mru_cnt + CNT_W'(1);
      if (is_lru && lru_cnt != '1) lru_cnt <= lru_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= AW'(NWAYS);
      flush_req <= 1'b0;
      flush_way <= '0;
    end else if (flush_req && flush_ack) begin
      flush_req <= 1'b0;
      active    <= active - AW'(1);
    end else if (go_down) begin
      flush_req <= 1'b1;
      flush_way <= PW'(active - AW'(1));
    end else if (go_up) begin
      active <= active + AW'(1);
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (&way_mask) && !flush_req); // R1
  AST_FLOOR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_mask) >= MIN_WAYS && $countones(way_mask) <= NWAYS); // R8
  AST_HOLD_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> $stable(way_mask)); // R5
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && flush_ack) |=> (!flush_req &&
      $countones(way_mask) == $countones($past(way_mask)) - 1)); // R5
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_mask ^ $past(way_mask)) <= 1); // R9
  AST_FLUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (way_mask[flush_way] && $countones(way_mask) == int'(flush_way) + 1)); // R4
  AST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    ((way_mask + NWAYS'(1)) & way_mask) == '0); // R11

endmodule

// File: tb/sim_way_gate_ctrl.sv
`timescale 1ns/1ps
module sim_way_gate_ctrl;
  localparam int NWAYS = 8;
  localparam int PW = 3;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_hit = 0, flush_ack = 0;
  logic [PW-1:0] acc_pos = '0;
  logic [15:0] interval_len = 16;
  logic [7:0] thr_hi = 4, thr_lo = 1;
  logic [NWAYS-1:0] way_mask;
  logic flush_req;
  logic [PW-1:0] flush_way;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  way_gate_ctrl #(.NWAYS(NWAYS), .CNT_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_pos(acc_pos), .interval_len(interval_len), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .flush_ack(flush_ack), .way_mask(way_mask),
    .flush_req(flush_req), .flush_way(flush_way));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(bit h, int p, int n);
    for (int k = 0; k < n; k++) begin
      acc_valid = 1; acc_hit = h; acc_pos = PW'(p);
      @(negedge clk);
      acc_valid = 0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic ack();
    flush_ack = 1;
    @(negedge clk);
    flush_ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 mask", way_mask, 8'hFF);
    chk("R1 req", flush_req, 0);
  endtask

  task automatic t_interval_and_flush();
    for (int k = 0; k < 15; k++) begin
      acc(1, 0, 1);
      @(negedge clk);
    end
    settle();
    chk("R2 no decision before length", flush_req, 0);
    chk("R2 mask", way_mask, 8'hFF);
    acc(1, 0, 1);
    settle();
    chk("R4 req", flush_req, 1);
    chk("R4 way", flush_way, 7);
    repeat (4) @(negedge clk);
    chk("R5 held mask", way_mask, 8'hFF);
    acc(1, 0, 16);
    settle();
    chk("R9 no decision while pending", way_mask, 8'hFF);
    chk("R9 req still one", flush_req, 1);
    ack();
    chk("R5 mask after ack", way_mask, 8'h7F);
    chk("R5 req dropped", flush_req, 0);
    repeat (3) @(negedge clk);
    chk("R9 single step", way_mask, 8'h7F);
  endtask

  task automatic t_hysteresis();
    acc(1, 0, 8); acc(1, 6, 8);
    settle();
    chk("R7 mask", way_mask, 8'h7F);
    chk("R7 req", flush_req, 0);
  endtask

  task automatic t_ignored();
    acc(1, 0, 4); acc(0, 6, 6); acc(1, 3, 6);
    settle();
    chk("R3 misses ignored req", flush_req, 1);
    chk("R3 way", flush_way, 6);
    ack();
    chk("R3 mask", way_mask, 8'h3F);
  endtask

  task automatic t_cleared();
    acc(1, 5, 4); acc(0, 0, 12);
    settle();
    chk("R10 cleared, R6 grow", way_mask, 8'h7F);
    chk("R6 no req", flush_req, 0);
  endtask

  task automatic t_saturate();
    interval_len = 115; thr_hi = 2;
    acc(1, 0, 80); acc(1, 6, 35);
    settle();
    chk("R10 saturated no req", flush_req, 0);
    chk("R10 mask", way_mask, 8'h7F);
    interval_len = 16; thr_hi = 4;
  endtask

  task automatic t_ceiling();
    acc(1, 6, 16);
    settle();
    chk("R6 grow to full", way_mask, 8'hFF);
    acc(1, 7, 16);
    settle();
    chk("R8 ceiling", way_mask, 8'hFF);
  endtask

  task automatic t_floor();
    for (int w = 7; w >= 2; w--) begin
      acc(1, 0, 16);
      settle();
      chk("R4 floor walk way", flush_way, w);
      ack();
    end
    chk("R8 at floor", way_mask, 8'h03);
    acc(1, 0, 16);
    settle();
    chk("R8 floor req", flush_req, 0);
    chk("R8 floor mask", way_mask, 8'h03);
    acc(1, 1, 16);
    settle();
    chk("R3 lru at two ways R11", way_mask, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_interval_and_flush();
    t_hysteresis();
    t_ignored();
    t_cleared();
    t_saturate();
    t_ceiling();
    t_floor();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule